// File: doc/BRIEF.md
# Phase Frequency Detector with Selectable Polarity

This block compares a divided reference clock with a divided feedback clock, both already brought into the system clock domain. Each input has its own edge-captured flag. A rising edge on the reference sets the reference flag and a rising edge on the feedback sets the feedback flag. A flag held alone drives a pump request. Once both flags are set, both are cleared after a fixed interval counted in system clocks. This antibacklash interval makes both requests pulse briefly even when the loop is in lock, so the transfer function has no dead zone.

A two-bit mode input controls the pump outputs. It can swap the two requests, for oscillators whose frequency falls as the tuning voltage rises. It can also open the loop, which forces both requests low and drops the drive enable that an external three-state pump stage uses.

A lock indication rises after a run of consecutive comparisons whose longest pulse stays within one clock of the antibacklash interval. The run length is a parameter; the default is 16.

Top module: `pfd_core`

## Requirements
- R1: A rising edge on `ref_in` (low at one clock edge, high at the next) sets the reference flag at the clock edge where `ref_in` is first sampled high, so in mode 00 `up` is high right after that edge; `fb_in` sets the feedback flag in the same way.
- R2: Once both flags are set, both clear exactly DELAY_CYCLES clocks later (default 3). In-phase inputs therefore give `up` and `dn` high together for DELAY_CYCLES clocks.
- R3: When one input leads the other by k clocks, the leading request stays high for DELAY_CYCLES+k clocks and the lagging one for DELAY_CYCLES clocks.
- R4: Modes 00 and 10 select positive polarity: `up` follows the reference flag, `dn` follows the feedback flag, and `drive_en` is 1.
- R5: Mode 11 selects negative polarity: `up` follows the feedback flag, `dn` follows the reference flag, and `drive_en` is 1.
- R6: Mode 01 opens the loop: `up` and `dn` are both held at 0 and `drive_en` is 0.
- R7: A rising edge that arrives while both flags wait for the joint clear is not lost. The flag for that input is set again at the clearing edge.
- R8: `locked` rises after LOCK_COUNT (default 16) consecutive comparisons whose longest request lasted at most DELAY_CYCLES+1 clocks. A comparison with a longer request drops `locked` at the clearing edge.
- R9: After reset both flags are clear, `up`=`dn`=0 and `locked`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Divided reference clock, synchronous to clk |
| fb_in | input | 1 | Divided feedback clock, synchronous to clk |
| mode | input | 2 | 00/10 positive, 11 negative, 01 loop open |
| up | output | 1 | Pump-up request |
| dn | output | 1 | Pump-down request |
| drive_en | output | 1 | High when the pump stage may drive |
| locked | output | 1 | Phase lock indication |

## Verification
The hardest case to reach is an edge that arrives inside the short joint-clear window. The stimulus places a second reference edge two clocks after a coincident pair and delays the feedback edge further. The scoreboard then expects one merged pulse, with a long `up` and two separate `dn` bursts. Lock entry and loss are reached by sending exactly the threshold number of aligned comparisons, then a one-clock skew that must keep lock, then a two-clock skew that must drop it.

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int DELAY_CYCLES = 3,
  parameter int LOCK_COUNT   = 16,
  parameter int WIDTH_BITS   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_in,
  input  logic       fb_in,
  input  logic [1:0] mode,
  output logic       up,
  output logic       dn,
  output logic       drive_en,
  output logic       locked
);
  localparam int CW = (DELAY_CYCLES < 2) ? 1 : $clog2(DELAY_CYCLES);
  localparam int LW = $clog2(LOCK_COUNT + 1);

  logic                  ref_d, fb_d;
  logic                  ref_flag, fb_flag;
  logic                  ref_pend, fb_pend;
  logic [CW-1:0]         clr_cnt;
  logic [WIDTH_BITS-1:0] wid;
  logic [LW-1:0]         good;

  wire ref_rise = ref_in & ~ref_d;
  wire fb_rise  = fb_in & ~fb_d;
  wire both     = ref_flag & fb_flag;
  wire clr_now  = both && (clr_cnt == CW'(DELAY_CYCLES - 1));

  wire [WIDTH_BITS:0] width_now = {1'b0, wid} + (WIDTH_BITS+1)'(1);
  wire                cmp_good  = width_now <= (WIDTH_BITS+1)'(DELAY_CYCLES + 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_d    <= 1'b0;
      fb_d     <= 1'b0;
      ref_flag <= 1'b0;
      fb_flag  <= 1'b0;
      ref_pend <= 1'b0;
      fb_pend  <= 1'b0;
      clr_cnt  <= '0;
    end else begin
      ref_d <= ref_in;
      fb_d  <= fb_in;
      if (clr_now) begin
        ref_flag <= ref_pend | ref_rise;
        fb_flag  <= fb_pend | fb_rise;
        ref_pend <= 1'b0;
        fb_pend  <= 1'b0;
        clr_cnt  <= '0;
      end else if (both) begin
        ref_pend <= ref_pend | ref_rise;
        fb_pend  <= fb_pend | fb_rise;
        clr_cnt  <= clr_cnt + CW'(1);
      end else begin
        ref_flag <= ref_flag | ref_rise;
        fb_flag  <= fb_flag | fb_rise;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wid  <= '0;
      good <= '0;
    end else if (clr_now) begin
      wid <= '0;
      if (!cmp_good)                 good <= '0;
      else if (good != LW'(LOCK_COUNT)) good <= good + LW'(1);
    end else if ((ref_flag | fb_flag) && (wid != '1)) begin
      wid <= wid + WIDTH_BITS'(1);
    end
  end

  wire loop_open = (mode == 2'b01);
  wire swap      = (mode == 2'b11);

  assign up       = ~loop_open & (swap ? fb_flag : ref_flag);
  assign dn       = ~loop_open & (swap ? ref_flag : fb_flag);
  assign drive_en = ~loop_open;
  assign locked   = (good == LW'(LOCK_COUNT));
endmodule

// File: rtl/pfd_core_chk.sv
module pfd_core_chk #(
  parameter int DELAY_CYCLES = 3,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          up,
  input logic          dn,
  input logic          drive_en,
  input logic          locked,
  input logic          ref_flag,
  input logic          fb_flag,
  input logic [CW-1:0] clr_cnt
);
  a_r2_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_flag && fb_flag) |-> (clr_cnt < CW'(DELAY_CYCLES)));

  a_r2_joint_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_flag) |-> $past(fb_flag));

  a_r6_open_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (!up && !dn && !drive_en));

  a_r4_drive_on: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b01) |-> drive_en);

  a_r8_lock_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ref_flag && fb_flag));
endmodule

bind pfd_core pfd_core_chk #(.DELAY_CYCLES(DELAY_CYCLES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .up(up), .dn(dn),
  .drive_en(drive_en), .locked(locked), .ref_flag(ref_flag),
  .fb_flag(fb_flag), .clr_cnt(clr_cnt)
);

// File: tb/sim_pfd_core.sv
`timescale 1ns/1ps
module sim_pfd_core;
  localparam int D = 3;
  localparam int LOCKN = 16;

  logic clk = 0, rst_n = 0, ref_in = 0, fb_in = 0;
  logic [1:0] mode = 2'b00;
  logic up, dn, drive_en, locked;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  pfd_core #(.DELAY_CYCLES(D), .LOCK_COUNT(LOCKN)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in), .mode(mode),
    .up(up), .dn(dn), .drive_en(drive_en), .locked(locked));

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int uw, input int dw, input string req);
    exp_q.push_back({uw[7:0], dw[7:0]});
    tag_q.push_back(req);
  endtask

  // monitor: measures each pulse group and compares with the scoreboard
  int uw_m = 0, dw_m = 0;
  bit in_p = 0;
  always begin
    @(posedge clk); #1;
    if (rst_n) begin
      if (up || dn) begin
        in_p = 1;
        if (up) uw_m++;
        if (dn) dw_m++;
      end else if (in_p) begin
        if (exp_q.size() == 0) begin
          check(0, "unexpected pulse", uw_m*256 + dw_m, 0);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(uw_m == int'(e[15:8]), {t, " up width"}, uw_m, int'(e[15:8]));
          check(dw_m == int'(e[7:0]), {t, " dn width"}, dw_m, int'(e[7:0]));
        end
        in_p = 0; uw_m = 0; dw_m = 0;
      end
    end
  end

  // driver: one comparison, fb lags ref by k clocks (negative k: fb leads)
  task automatic pair(input int k, input string req);
    int rs, fs, mx, ur, df;
    bit quiet_bad = 0;
    rs = (k < 0) ? 2 - k : 2;
    fs = (k < 0) ? 2 : 2 + k;
    mx = (rs > fs) ? rs : fs;
    ur = mx + D - rs;
    df = mx + D - fs;
    if (mode == 2'b11) push(df, ur, req);
    else if (mode != 2'b01) push(ur, df, req);
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      ref_in = (c == rs);
      fb_in  = (c == fs);
      if (mode == 2'b01) begin
        @(posedge clk); #1;
        if (up || dn || drive_en) quiet_bad = 1;
      end
    end
    if (mode == 2'b01) check(!quiet_bad, "R6 loop open quiet", quiet_bad, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; ref_in = 0; fb_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(4 * 150000);
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    check(!up && !dn, "R9 requests idle", {up, dn}, 0);
    check(!locked, "R9 unlocked", locked, 0);
    check(drive_en, "R4 drive enabled", drive_en, 1);

    // R1 timing of the first edge, coincident pair gives R2 widths
    push(D, D, "R2 in-phase");
    @(negedge clk); ref_in = 1; fb_in = 1;
    @(posedge clk); #1;
    check(up && dn, "R1 set on first high sample", {up, dn}, 3);
    @(negedge clk); ref_in = 0; fb_in = 0;
    repeat (20) @(negedge clk);

    pair(2, "R3 ref leads");
    pair(-3, "R3 fb leads");
    mode = 2'b10;
    pair(1, "R4 mode 10");
    mode = 2'b11;
    pair(2, "R5 swapped");
    @(negedge clk);
    check(drive_en, "R5 drive enabled", drive_en, 1);
    mode = 2'b01;
    pair(1, "R6");
    mode = 2'b00;

    // R7: second ref edge inside the clear window
    push(13, 6, "R7 edge kept");
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      ref_in = (c == 0) || (c == 2);
      fb_in  = (c == 0) || (c == 10);
    end

    // R8 lock entry and exit
    do_reset();
    for (int i = 0; i < LOCKN - 1; i++) pair(0, "R8 aligned");
    check(!locked, "R8 not yet locked", locked, 0);
    pair(0, "R8 aligned");
    check(locked, "R8 locked after run", locked, 1);
    pair(1, "R8 one clock skew");
    check(locked, "R8 lock kept at limit", locked, 1);
    pair(2, "R8 two clock skew");
    check(!locked, "R8 lock lost", locked, 0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule